// File: doc/BRIEF.md
# SD Command Line Engine

This block runs the command half of an SD host controller. Software loads a 32-bit argument and a transfer mode, then writes a 16-bit command word. That write starts the command. The engine shifts a 48-bit command token out on the CMD line, most significant bit first, and appends a CRC7 it computes itself. It then waits for the card's response and shifts it in. It checks the response's CRC, index and end bit as the command word asks, and stores the payload in a 128-bit response register.

The engine keeps two inhibit flags in a present-state word. The CMD flag guards the command line. The DAT flag guards the data lines. The engine sends one-cycle pulses toward the interrupt status unit: command complete, transfer complete for the busy case, and four kinds of error. The SD clock is the block clock. Data-line block transfers are handled elsewhere; that path reports its end through a done input.

Top module: `sd_cmd_engine`

## Requirements
- R1: A started command drives cmd_oe_o high for exactly 48 cycles. In that time cmd_o sends, MSB first: a 0, a 1, the 6-bit index (command word bits 13:8), the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero start value, computed over the first 40 bits) and a closing 1.
- R2: The response type is command word bits 1:0: 0 none, 1 136-bit, 2 48-bit, 3 48-bit with busy. With type 0 nothing is received. cmd_done_o pulses in the cycle after the last token bit, and resp_o is unchanged.
- R3: A good 48-bit response pulses cmd_done_o. It places the 32 bits that follow the index field into resp_o[31:0] and leaves resp_o[127:32] unchanged.
- R4: A good 136-bit response sets resp_o to 8 zero bits followed by the 120 bits that sit between the reserved header byte and the CRC field. The CRC byte is not stored.
- R5: If no start bit (a 0) is seen on cmd_i within 64 cycles after the token ends, err_tmo_o pulses. A start bit on the 61st cycle is accepted.
- R6: When command word bit 3 is set, a CRC7 mismatch on the response pulses err_crc_o. With bit 3 clear, a mismatch is ignored. A response with any error pulses no cmd_done_o and does not change resp_o.
- R7: When command word bit 4 is set, a 48-bit response whose index field differs from the sent index pulses err_idx_o. With bit 4 clear, the mismatch is ignored.
- R8: A response whose last bit is 0 pulses err_end_o.
- R9: present_o bit 0 (CMD inhibit) is set from the accepted write until completion or error. Bit 1 (DAT inhibit) is set for commands with bit 5 (data present) set or with response type 3. Bit 16 follows card_i. For a data command, data_done_i clears bit 1. Any error clears both flags. All other bits read 0.
- R10: After a good type-3 response, the engine waits for dat0_i to be 1. It then pulses xfer_done_o and clears DAT inhibit. CMD inhibit is already clear during this wait.
- R11: A command-word write is ignored in any of these cases: CMD inhibit is set; no card is present; or DAT inhibit is set and the command needs the DAT lines and is not an abort.
- R12: A command of type 3 (command word bits 7:6) is an abort. It is accepted while DAT inhibit is set. When it completes without busy, it clears DAT inhibit.
- R13: xfer_mode_o holds the transfer mode captured at the last accepted write. Its bits are: 0 DMA, 1 block count enable, 2 auto stop, 4 read, 5 multi-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and SD clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 16 | Command word |
| arg_i | input | 32 | Command argument |
| mode_i | input | 16 | Transfer mode |
| card_i | input | 1 | Card inserted |
| dat0_i | input | 1 | DAT0 line level |
| data_done_i | input | 1 | Data path finished its transfer |
| cmd_i | input | 1 | CMD line level from the card |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD line drive enable |
| present_o | output | 32 | Present state word |
| xfer_mode_o | output | 16 | Captured transfer mode |
| resp_o | output | 128 | Response words |
| cmd_done_o | output | 1 | Command complete pulse |
| xfer_done_o | output | 1 | Busy released pulse |
| err_tmo_o | output | 1 | Response timeout pulse |
| err_crc_o | output | 1 | Response CRC error pulse |
| err_idx_o | output | 1 | Response index error pulse |
| err_end_o | output | 1 | Response end bit error pulse |

## Verification
The bench sends responses with a flipped CRC bit, a wrong index and a zeroed end bit. It sends each with its check enabled and then disabled, so a design that ignores the enable bits either misses errors or raises false ones. A response that starts late but inside the window, and a card that never answers, bracket the timeout; an off-by-many counter either times out early or hangs. A second write during a transfer, a data command while DAT inhibit holds, and an abort in the same state show whether the gating wrongly starts a second token or wrongly blocks the abort. The busy case holds DAT0 low past the response; a design that ends busy too soon raises transfer complete early or clears the wrong flag.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TMO_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr_i,
  input  logic [15:0]  cmd_word_i,
  input  logic [31:0]  arg_i,
  input  logic [15:0]  mode_i,
  input  logic         card_i,
  input  logic         dat0_i,
  input  logic         data_done_i,
  input  logic         cmd_i,
  output logic         cmd_o,
  output logic         cmd_oe_o,
  output logic [31:0]  present_o,
  output logic [15:0]  xfer_mode_o,
  output logic [127:0] resp_o,
  output logic         cmd_done_o,
  output logic         xfer_done_o,
  output logic         err_tmo_o,
  output logic         err_crc_o,
  output logic         err_idx_o,
  output logic         err_end_o
);
  localparam int TW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_t;

  st_t           st;
  logic [7:0]    cnt;
  logic [39:0]   txsh;
  logic [6:0]    crc;
  logic [135:0]  rx;
  logic [TW-1:0] tmr;
  logic [13:0]   cw;
  logic          inh_dat, busy_wait;

  function automatic logic [6:0] crc_step(logic [6:0] c, logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  endfunction

  logic [1:0]   w_rtype;
  logic         w_abort, w_needs_dat, issue;
  logic         long_rsp, is_abort, in_crc, crc_bad, idx_bad, end_bad, any_err;
  logic [7:0]   last;
  logic [135:0] rxn;
  logic         unused_bits;

  assign w_rtype     = cmd_word_i[1:0];
  assign w_abort     = cmd_word_i[7:6] == 2'b11;
  assign w_needs_dat = cmd_word_i[5] | (w_rtype == 2'd3);
  assign issue       = cmd_wr_i && card_i && st == S_IDLE && (!inh_dat || w_abort || !w_needs_dat);

  assign long_rsp = cw[1:0] == 2'd1;
  assign is_abort = cw[7:6] == 2'b11;
  assign last     = long_rsp ? 8'd135 : 8'd47;
  assign rxn      = {rx[134:0], cmd_i};
  assign in_crc   = long_rsp ? (cnt >= 8'd8 && cnt < 8'd128) : (cnt < 8'd40);
  assign crc_bad  = cw[3] && (rxn[7:1] != crc);
  assign idx_bad  = cw[4] && !long_rsp && (rxn[45:40] != cw[13:8]);
  assign end_bad  = !cmd_i;
  assign any_err  = crc_bad | idx_bad | end_bad;

  assign cmd_oe_o  = st == S_SEND;
  assign cmd_o     = (st != S_SEND) ? 1'b1 : (cnt < 8'd40) ? txsh[39] : (cnt < 8'd47) ? crc[6] : 1'b1;
  assign present_o = {15'b0, card_i, 14'b0, inh_dat, st != S_IDLE};

  assign unused_bits = ^{cmd_word_i[15:14], cw[2], rx[135], rxn[135:128], rxn[46]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; txsh <= '0; crc <= '0; rx <= '0; tmr <= '0; cw <= '0;
      inh_dat <= 1'b0; busy_wait <= 1'b0; xfer_mode_o <= '0; resp_o <= '0;
      cmd_done_o <= 1'b0; xfer_done_o <= 1'b0;
      err_tmo_o <= 1'b0; err_crc_o <= 1'b0; err_idx_o <= 1'b0; err_end_o <= 1'b0;
    end else begin
      cmd_done_o <= 1'b0; xfer_done_o <= 1'b0;
      err_tmo_o <= 1'b0; err_crc_o <= 1'b0; err_idx_o <= 1'b0; err_end_o <= 1'b0;
      if (data_done_i && !busy_wait) inh_dat <= 1'b0;
      if (busy_wait && dat0_i) begin
        busy_wait <= 1'b0; inh_dat <= 1'b0; xfer_done_o <= 1'b1;
      end
      case (st)
        S_IDLE: if (issue) begin
          cw <= cmd_word_i[13:0];
          xfer_mode_o <= mode_i;
          txsh <= {2'b01, cmd_word_i[13:8], arg_i};
          crc <= '0; cnt <= '0; st <= S_SEND;
          if (w_needs_dat) inh_dat <= 1'b1;
        end
        S_SEND: begin
          cnt <= cnt + 8'd1;
          if (cnt < 8'd40) begin
            crc <= crc_step(crc, txsh[39]);
            txsh <= {txsh[38:0], 1'b0};
          end else crc <= {crc[5:0], 1'b0};
          if (cnt == 8'd47) begin
            crc <= '0; tmr <= '0;
            if (cw[1:0] == 2'd0) begin
              st <= S_IDLE; cmd_done_o <= 1'b1;
              if (is_abort) begin inh_dat <= 1'b0; busy_wait <= 1'b0; end
            end else st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!cmd_i) begin
            st <= S_RECV; cnt <= 8'd1; rx <= '0;
          end else if (tmr == TW'(TMO_CYCLES - 1)) begin
            st <= S_IDLE; err_tmo_o <= 1'b1; inh_dat <= 1'b0; busy_wait <= 1'b0;
          end else tmr <= tmr + 1'b1;
        end
        S_RECV: begin
          rx <= rxn;
          cnt <= cnt + 8'd1;
          if (in_crc) crc <= crc_step(crc, cmd_i);
          if (cnt == last) begin
            st <= S_IDLE;
            if (any_err) begin
              err_crc_o <= crc_bad; err_idx_o <= idx_bad; err_end_o <= end_bad;
              inh_dat <= 1'b0; busy_wait <= 1'b0;
            end else begin
              cmd_done_o <= 1'b1;
              if (long_rsp) resp_o <= {8'h00, rxn[127:8]};
              else resp_o[31:0] <= rxn[39:8];
              if (cw[1:0] == 2'd3) busy_wait <= 1'b1;
              else if (is_abort) begin inh_dat <= 1'b0; busy_wait <= 1'b0; end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_o |-> !(err_tmo_o | err_crc_o | err_idx_o | err_end_o));
  p_xfer_after_dat0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> ($past(dat0_i) && !present_o[1]));
  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && present_o[0]) |=> $stable(xfer_mode_o));
  p_oe_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe_o |-> present_o[0]);
  p_end_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe_o) |-> $past(cmd_o));
endmodule

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, card = 1, dat0 = 1, data_done = 0, cmd_in = 1;
  logic [15:0] cmd_word = 0, mode = 0;
  logic [31:0] arg = 0;
  logic cmd_o, cmd_oe, cmd_done, xfer_done, e_tmo, e_crc, e_idx, e_end;
  logic [31:0] present;
  logic [15:0] xmode;
  logic [127:0] resp;

  always #4 clk = ~clk;

  sd_cmd_engine dut (.clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_word_i(cmd_word), .arg_i(arg),
    .mode_i(mode), .card_i(card), .dat0_i(dat0), .data_done_i(data_done), .cmd_i(cmd_in),
    .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .present_o(present), .xfer_mode_o(xmode), .resp_o(resp),
    .cmd_done_o(cmd_done), .xfer_done_o(xfer_done), .err_tmo_o(e_tmo), .err_crc_o(e_crc),
    .err_idx_o(e_idx), .err_end_o(e_end));

  typedef struct { int kind; logic [127:0] val; string req; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  logic [127:0] resp_model = 0;

  logic rsp_en = 0;
  logic [135:0] rsp_bits;
  int rsp_len = 48, rsp_gap = 2;

  function automatic logic [6:0] crc7(logic [135:0] v, int n);
    logic [6:0] c = 0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (act !== expv) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, expv); end
  endtask

  task automatic push(input int kind, input logic [127:0] val, input string req);
    exp_t e; e.kind = kind; e.val = val; e.req = req; q.push_back(e);
  endtask

  task automatic pop_cmp(input int kind, input logic [127:0] val);
    exp_t e;
    total++;
    if (q.size() == 0) begin
      bad++; $display("FAIL unexpected event kind=%0d actual=%0h expected=none", kind, val);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.val !== val) begin
        bad++; $display("FAIL %s actual=%0d:%0h expected=%0d:%0h", e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  logic [47:0] tok; int tn = 0;
  always @(negedge clk) if (rst_n) begin
    if (cmd_oe) begin tok = {tok[46:0], cmd_o}; tn++; end
    else if (tn > 0) begin pop_cmp(0, {80'b0, tok}); tn = 0; end
    if (cmd_done) pop_cmp(1, resp);
    if (e_tmo | e_crc | e_idx | e_end) pop_cmp(2, {124'b0, e_tmo, e_crc, e_idx, e_end});
    if (xfer_done) pop_cmp(3, 128'b0);
  end

  logic oe_q = 0;
  initial forever begin
    @(negedge clk);
    if (oe_q && !cmd_oe && rsp_en) begin
      repeat (rsp_gap) @(negedge clk);
      for (int i = rsp_len - 1; i >= 0; i--) begin cmd_in = rsp_bits[i]; @(negedge clk); end
      cmd_in = 1;
    end
    oe_q = cmd_oe;
  end

  function automatic logic [15:0] cw(int idx, int ctype, bit data, bit ichk, bit cchk, int rtype);
    return {2'b00, 6'(idx), 2'(ctype), data, ichk, cchk, 1'b0, 2'(rtype)};
  endfunction

  task automatic exp_token(input logic [15:0] w, input logic [31:0] a, input string req);
    logic [39:0] t = {2'b01, w[13:8], a};
    push(0, {80'b0, t, crc7({96'b0, t}, 40), 1'b1}, req);
  endtask

  function automatic logic [135:0] r1(int idx, logic [31:0] st, bit crcflip, bit endb);
    logic [39:0] b = {2'b00, 6'(idx), st};
    return {88'b0, b, crc7({96'b0, b}, 40) ^ {6'b0, crcflip}, endb};
  endfunction

  task automatic issue(input logic [15:0] w, input logic [31:0] a, input logic [15:0] m);
    @(negedge clk); cmd_word = w; arg = a; mode = m; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic short_cmd(input logic [15:0] w, input logic [31:0] a, input logic [31:0] st,
                           input int ridx, input bit flip, input bit endb, input logic [3:0] err, input string req);
    rsp_en = 1; rsp_len = 48; rsp_bits = r1(ridx, st, flip, endb);
    exp_token(w, a, req);
    if (err == 0) begin resp_model[31:0] = st; push(1, resp_model, req); end
    else push(2, {124'b0, err}, req);
    issue(w, a, 16'h0000);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [119:0] body;
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    check("R9 reset present", {96'b0, present}, 128'h1_0000);
    check("R9 reset oe", {127'b0, cmd_oe}, 0);
    check("R3 reset resp", resp, 0);

    w = cw(0, 0, 0, 0, 0, 0); rsp_en = 0;
    exp_token(w, 32'h0, "R1 R2 no response"); push(1, resp_model, "R2 no response");
    issue(w, 32'h0, 0); settle();

    short_cmd(cw(8, 0, 0, 1, 1, 2), 32'h1AA, 32'h0000_01AA, 8, 0, 1, 0, "R3 R1 short ok");

    body = {24'hC3A517, {3{32'h5A0F_E1D2}}};
    w = cw(2, 0, 0, 0, 1, 1);
    rsp_en = 1; rsp_len = 136; rsp_gap = 4;
    rsp_bits = {2'b00, 6'h3F, body, crc7({16'b0, body}, 120), 1'b1};
    exp_token(w, 32'h0, "R4 long"); resp_model = {8'h00, body}; push(1, resp_model, "R4 long");
    issue(w, 32'h0, 0); settle();
    rsp_len = 48; rsp_gap = 2;

    w = cw(9, 0, 0, 1, 1, 2); rsp_en = 0;
    exp_token(w, 32'h77, "R5 timeout"); push(2, 128'b1000, "R5 timeout");
    issue(w, 32'h77, 0); settle();
    check("R5 cmd inhibit cleared after timeout", {127'b0, present[0]}, 0);
    rsp_gap = 60;
    short_cmd(cw(9, 0, 0, 1, 1, 2), 32'h78, 32'hCAFE_0001, 9, 0, 1, 0, "R5 late start accepted");
    rsp_gap = 2;

    short_cmd(cw(13, 0, 0, 1, 1, 2), 32'h1, 32'h1234_5678, 13, 1, 1, 4'b0100, "R6 crc error");
    check("R6 resp unchanged after error", resp, resp_model);
    short_cmd(cw(13, 0, 0, 1, 0, 2), 32'h1, 32'h1234_5679, 13, 1, 1, 0, "R6 crc check off");

    short_cmd(cw(17, 0, 0, 1, 1, 2), 32'h2, 32'hABCD_0000, 18, 0, 1, 4'b0010, "R7 index error");
    short_cmd(cw(17, 0, 0, 0, 1, 2), 32'h2, 32'hABCD_0001, 18, 0, 1, 0, "R7 index check off");

    short_cmd(cw(55, 0, 0, 1, 1, 2), 32'h3, 32'h0BAD_0E0D, 55, 0, 0, 4'b0001, "R8 end bit zero");

    dat0 = 0; w = cw(7, 0, 0, 1, 1, 3);
    rsp_en = 1; rsp_bits = r1(7, 32'h0000_0900, 0, 1);
    exp_token(w, 32'h10, "R10 busy token"); resp_model[31:0] = 32'h0000_0900; push(1, resp_model, "R10 busy done");
    issue(w, 32'h10, 0); settle(); repeat (10) @(negedge clk);
    check("R10 DAT inhibit held while busy", {126'b0, present[1:0]}, 2'b10);
    push(3, 0, "R10 busy release"); dat0 = 1; settle();
    check("R10 DAT inhibit cleared", {127'b0, present[1]}, 0);

    w = cw(3, 0, 0, 0, 0, 0); rsp_en = 0;
    exp_token(w, 32'h5, "R11 first token"); push(1, resp_model, "R11 first done");
    issue(w, 32'h5, 16'h0012);
    repeat (4) @(negedge clk);
    cmd_word = cw(4, 0, 0, 0, 0, 0); mode = 16'h0021; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
    settle(); repeat (80) @(negedge clk);
    check("R13 mode captured, R11 second write ignored", {112'b0, xmode}, 16'h0012);

    w = cw(18, 0, 1, 1, 1, 2); rsp_en = 1;
    short_cmd(w, 32'h40, 32'h0000_0D00, 18, 0, 1, 0, "R9 data command");
    check("R9 DAT inhibit for data command", {127'b0, present[1]}, 1);
    issue(cw(24, 0, 1, 1, 1, 2), 32'h41, 16'h0003);
    check("R11 data command blocked by DAT inhibit", {127'b0, present[0]}, 0);
    repeat (100) @(negedge clk);
    short_cmd(cw(13, 0, 0, 1, 1, 2), 32'h42, 32'h0000_0E00, 13, 0, 1, 0, "R11 non-data command passes");
    short_cmd(cw(12, 3, 0, 1, 1, 2), 32'h43, 32'h0000_0F00, 12, 0, 1, 0, "R12 abort accepted");
    check("R12 abort clears DAT inhibit", {127'b0, present[1]}, 0);
    short_cmd(w, 32'h44, 32'h0000_0D01, 18, 0, 1, 0, "R9 data command again");
    data_done = 1; @(negedge clk); data_done = 0;
    check("R9 data done clears DAT inhibit", {127'b0, present[1]}, 0);

    card = 0; @(negedge clk);
    check("R9 card absent bit", {127'b0, present[16]}, 0);
    issue(cw(0, 0, 0, 0, 0, 0), 32'h0, 0);
    check("R11 no card write ignored", {127'b0, present[0]}, 0);
    repeat (60) @(negedge clk);
    check("R11 nothing pending", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule